// File: doc/BRIEF.md
# Virtually Indexed Set-Associative Tag Lookup

This block holds the tag store and hit logic of a 32 KB, four-way set-associative cache with 32-byte lines. The set is always taken from the virtual address of a request. The tag that is stored and compared comes from one of two places, fixed when the block is built. In virtual-tag mode it is the upper part of the virtual address. In physical-tag mode it is the upper part of a translated physical address, which arrives from an external translation stage one cycle after the request.

A lookup takes two cycles. In the first, the addressed set is read. In the second, the tag is compared against every way, and the block reports hit, the hitting way and, on a miss, a replacement way. A separate fill port writes a tag into a chosen way and marks it valid. A way-enable mask restricts the active associativity, down to a single direct-mapped way.

Because the set comes from the virtual address, two virtual aliases of the same physical line behave in a known way. In physical-tag mode they share a line when their page-colour bit (virtual bit 12) agrees. In virtual-tag mode they never share a line.

Top module: `vtag_lookup`

## Requirements
- R1: After reset, every entry is invalid and `rsp_valid` is low. A lookup issued right after reset misses in every mode.
- R2: A request sampled with `req_valid` high at clock edge N yields `rsp_valid` high after edge N+1 for exactly one cycle. Without a request, `rsp_valid` stays low.
- R3: The set is virtual-address bits 12..5 (256 sets). A lookup whose tag matches a stored line but whose bits 12..5 differ misses.
- R4: In physical-tag mode, the compared tag is `xlat_pa[31:13]`, sampled in the cycle after the request. A virtual alias with equal bits 12..5 and the same physical address hits. A different physical tag misses.
- R5: In virtual-tag mode, the compared tag is `req_va[31:13]`. Two different virtual addresses that map the same physical address miss against each other's lines, including when only one way is enabled.
- R6: Aliases that differ in page-colour bit 12 index different sets and miss against each other in both modes.
- R7: A hit needs a valid entry, an equal tag and an enabled way. `rsp_way` gives that way's number, 0..3, and a line in a disabled way never hits.
- R8: A fill with `fill_valid` high writes the mode's tag into way `fill_way` of set `fill_va[12:5]` and sets its valid bit. A fill aimed at a disabled way changes neither the entry nor the replacement state.
- R9: On a miss, `rsp_victim` is the first enabled way at or after the set's replacement pointer, wrapping around. A fill to way w sets that set's pointer to w+1 mod 4, and reset clears every pointer to 0.
- R10: With `way_en` = 4'b0001, every miss names way 0 as victim, and a fill of a new tag replaces the old line.
- R11: Address bits 4..0 (byte in line) have no effect on the lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address of the lookup |
| xlat_pa | input | 32 | Translated physical address, valid the cycle after the request |
| way_en | input | 4 | Enabled ways mask |
| fill_valid | input | 1 | Fill strobe |
| fill_va | input | 32 | Virtual address of the line being filled |
| fill_pa | input | 32 | Physical address of the line being filled |
| fill_way | input | 2 | Way written by the fill |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 2 | Hitting way (0 on miss) |
| rsp_victim | output | 2 | Replacement way, meaningful on a miss |

## Verification
A corrupted valid bit or tag shows up on the very next lookup of that set, two cycles after the request. It appears as a hit that should be a miss, or the reverse, and the alias pairs in both tag modes catch a wrong tag source. A replacement pointer that is stuck, or that a blocked fill moves, shows up in `rsp_victim` on the first miss that follows. A wrong index slice shows up as a hit from a neighbouring set or as a lost line. The bench runs one virtual-tag and one physical-tag instance side by side on the same stimulus, so any disagreement between the two modes is checked on every lookup.

// File: rtl/vtag_pkg.sv
package vtag_pkg;

    localparam int ADDR_W     = 32;
    localparam int LINE_BYTES = 32;
    localparam int NUM_WAYS   = 4;
    localparam int WAY_BYTES  = 8192;

    localparam int OFF_W    = $clog2(LINE_BYTES);
    localparam int SET_W    = $clog2(WAY_BYTES) - OFF_W;
    localparam int NUM_SETS = 1 << SET_W;
    localparam int TAG_LSB  = OFF_W + SET_W;
    localparam int TAG_W    = ADDR_W - TAG_LSB;
    localparam int WAY_W    = $clog2(NUM_WAYS);

    typedef logic [TAG_W-1:0]    tag_t;
    typedef logic [SET_W-1:0]    set_t;
    typedef logic [WAY_W-1:0]    way_t;
    typedef logic [NUM_WAYS-1:0] wmask_t;

    typedef enum logic {
        TAG_SRC_VIRT = 1'b0,
        TAG_SRC_PHYS = 1'b1
    } tag_src_e;

    typedef struct packed {
        logic valid;
        tag_t tag;
    } entry_t;

    function automatic set_t set_of(input logic [ADDR_W-1:0] a);
        return a[TAG_LSB-1:OFF_W];
    endfunction

    function automatic tag_t tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:TAG_LSB];
    endfunction

    // First enabled way at or after start, wrapping; 0 if none enabled.
    function automatic way_t pick_victim(input way_t start, input wmask_t en);
        way_t res;
        way_t w;
        logic found;
        res   = '0;
        found = 1'b0;
        for (int k = 0; k < NUM_WAYS; k++) begin
            w = way_t'(int'(start) + k);
            if (!found && en[w]) begin
                res   = w;
                found = 1'b1;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/vtag_array.sv
module vtag_array
    import vtag_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd_en,
    input  set_t                   rd_set,
    output entry_t [NUM_WAYS-1:0]  rd_entries,
    input  logic                   wr_en,
    input  set_t                   wr_set,
    input  way_t                   wr_way,
    input  tag_t                   wr_tag
);

    tag_t   tag_q   [NUM_SETS][NUM_WAYS];
    wmask_t valid_q [NUM_SETS];
    entry_t [NUM_WAYS-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way] <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                valid_q[s] <= '0;
            end
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                rd_q[w].valid <= valid_q[rd_set][w];
                rd_q[w].tag   <= tag_q[rd_set][w];
            end
        end
    end

    assign rd_entries = rd_q;

endmodule

// File: rtl/vtag_compare.sv
module vtag_compare
    import vtag_pkg::*;
(
    input  entry_t [NUM_WAYS-1:0] entries,
    input  tag_t                  key,
    input  wmask_t                way_en,
    output logic                  any_hit,
    output way_t                  hit_way
);

    wmask_t match;

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
        assign match[g] = entries[g].valid && way_en[g] && (entries[g].tag == key);
    end

    always_comb begin
        hit_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit_way = way_t'(w);
            end
        end
    end

    assign any_hit = |match;

endmodule

// File: rtl/vtag_victim.sv
module vtag_victim
    import vtag_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   upd_en,
    input  set_t   upd_set,
    input  way_t   upd_way,
    input  set_t   rd_set,
    input  wmask_t way_en,
    output way_t   victim
);

    way_t ptr_q [NUM_SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                ptr_q[s] <= '0;
            end
        end else if (upd_en) begin
            ptr_q[upd_set] <= way_t'(int'(upd_way) + 1);
        end
    end

    assign victim = pick_victim(ptr_q[rd_set], way_en);

endmodule

// File: rtl/vtag_lookup.sv
module vtag_lookup
    import vtag_pkg::*;
#(
    parameter tag_src_e TAG_SRC = TAG_SRC_PHYS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_va,
    input  logic [ADDR_W-1:0]   xlat_pa,
    input  logic [NUM_WAYS-1:0] way_en,
    input  logic                fill_valid,
    input  logic [ADDR_W-1:0]   fill_va,
    input  logic [ADDR_W-1:0]   fill_pa,
    input  logic [WAY_W-1:0]    fill_way,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [WAY_W-1:0]    rsp_way,
    output logic [WAY_W-1:0]    rsp_victim
);

    // Stage 1: set read
    logic s1_valid;
    set_t s1_set;
    tag_t s1_vtag;
    entry_t [NUM_WAYS-1:0] s1_entries;

    // Stage 2: compare
    tag_t key;
    tag_t fill_tag;
    logic cmp_hit;
    way_t cmp_way;
    way_t cmp_victim;
    logic fill_ok;

    assign fill_ok = fill_valid && way_en[fill_way];

    if (TAG_SRC == TAG_SRC_PHYS) begin : g_phys
        assign key      = tag_of(xlat_pa);
        assign fill_tag = tag_of(fill_pa);
    end else begin : g_virt
        assign key      = s1_vtag;
        assign fill_tag = tag_of(fill_va);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_set   <= '0;
            s1_vtag  <= '0;
        end else begin
            s1_valid <= req_valid;
            if (req_valid) begin
                s1_set  <= set_of(req_va);
                s1_vtag <= tag_of(req_va);
            end
        end
    end

    vtag_array u_array (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (req_valid),
        .rd_set     (set_of(req_va)),
        .rd_entries (s1_entries),
        .wr_en      (fill_ok),
        .wr_set     (set_of(fill_va)),
        .wr_way     (fill_way),
        .wr_tag     (fill_tag)
    );

    vtag_compare u_cmp (
        .entries (s1_entries),
        .key     (key),
        .way_en  (way_en),
        .any_hit (cmp_hit),
        .hit_way (cmp_way)
    );

    vtag_victim u_victim (
        .clk     (clk),
        .rst     (rst),
        .upd_en  (fill_ok),
        .upd_set (set_of(fill_va)),
        .upd_way (fill_way),
        .rd_set  (s1_set),
        .way_en  (way_en),
        .victim  (cmp_victim)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_way    <= '0;
            rsp_victim <= '0;
        end else begin
            rsp_valid <= s1_valid;
            if (s1_valid) begin
                rsp_hit    <= cmp_hit;
                rsp_way    <= cmp_hit ? cmp_way : '0;
                rsp_victim <= cmp_victim;
            end
        end
    end

endmodule

// File: rtl/vtag_lookup_chk.sv
module vtag_lookup_chk
    import vtag_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [NUM_WAYS-1:0] way_en,
    input logic                rsp_valid,
    input logic                rsp_hit,
    input logic [WAY_W-1:0]    rsp_way,
    input logic [WAY_W-1:0]    rsp_victim
);

    logic [NUM_WAYS-1:0] way_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            way_en_q <= '0;
        end else begin
            way_en_q <= way_en;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_valid);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid, 2) |-> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid, 2));

    // R7
    hit_in_enabled_way_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> way_en_q[rsp_way]);

    // R9
    victim_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit && (way_en_q != '0)) |-> way_en_q[rsp_victim]);

    // R10
    direct_mapped_victim_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit && (way_en_q == NUM_WAYS'(1))) |-> (rsp_victim == '0));

endmodule

bind vtag_lookup vtag_lookup_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .way_en     (way_en),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_way    (rsp_way),
    .rsp_victim (rsp_victim)
);

// File: tb/tb_vtag_lookup.sv
module tb_vtag_lookup;
    import vtag_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [31:0] xlat_pa = '0;
    logic [3:0]  way_en = 4'b1111;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_va = '0;
    logic [31:0] fill_pa = '0;
    logic [1:0]  fill_way = '0;

    logic       rv_p, hit_p, rv_v, hit_v;
    logic [1:0] way_p, vic_p, way_v, vic_v;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // physical-tag instance
    vtag_lookup #(.TAG_SRC(TAG_SRC_PHYS)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .xlat_pa(xlat_pa), .way_en(way_en), .fill_valid(fill_valid),
        .fill_va(fill_va), .fill_pa(fill_pa), .fill_way(fill_way),
        .rsp_valid(rv_p), .rsp_hit(hit_p), .rsp_way(way_p), .rsp_victim(vic_p)
    );

    // virtual-tag instance
    vtag_lookup #(.TAG_SRC(TAG_SRC_VIRT)) dut_va (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .xlat_pa(xlat_pa), .way_en(way_en), .fill_valid(fill_valid),
        .fill_va(fill_va), .fill_pa(fill_pa), .fill_way(fill_way),
        .rsp_valid(rv_v), .rsp_hit(hit_v), .rsp_way(way_v), .rsp_victim(vic_v)
    );

    typedef struct packed {
        logic        is_fill;
        logic [31:0] va;
        logic [31:0] pa;
        logic [1:0]  way;
        logic        hp;
        logic [1:0]  wp;
        logic        hv;
        logic [1:0]  wv;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 32'h0000_2040, 32'h8000_0040, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0}, // R1 empty
        '{1'b1, 32'h0000_2040, 32'h8000_0040, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0}, // R8 fill
        '{1'b0, 32'h0000_2040, 32'h8000_0040, 2'd0, 1'b1, 2'd0, 1'b1, 2'd0}, // R7 hit
        '{1'b0, 32'h0000_205F, 32'h8000_0040, 2'd0, 1'b1, 2'd0, 1'b1, 2'd0}, // R11 offset
        '{1'b0, 32'h0000_6040, 32'h8000_0040, 2'd0, 1'b1, 2'd0, 1'b0, 2'd0}, // R4 R5 alias
        '{1'b0, 32'h0000_3040, 32'h8000_0040, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0}, // R6 colour
        '{1'b0, 32'h0000_2060, 32'h8000_0040, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0}, // R3 index
        '{1'b0, 32'h0000_2040, 32'h9000_0040, 2'd0, 1'b0, 2'd0, 1'b1, 2'd0}  // R4 R5 source
    };

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic do_fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] w);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_va    = va;
        fill_pa    = pa;
        fill_way   = w;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // request at edge N, result visible after edge N+1
    task automatic look(input logic [31:0] va, input logic [31:0] pa, input string rq,
                        input logic hp, input logic [1:0] wp,
                        input logic hv, input logic [1:0] wv);
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = va;
        xlat_pa   = pa;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R2", "phys rsp_valid", int'(rv_p), 1);
        chk("R2", "virt rsp_valid", int'(rv_v), 1);
        chk(rq, "phys hit", int'(hit_p), int'(hp));
        chk(rq, "virt hit", int'(hit_v), int'(hv));
        if (hp) chk(rq, "phys way", int'(way_p), int'(wp));
        if (hv) chk(rq, "virt way", int'(way_v), int'(wv));
    endtask

    task automatic vic(input string rq, input logic [1:0] vp, input logic [1:0] vv);
        chk(rq, "phys victim", int'(vic_p), int'(vp));
        chk(rq, "virt victim", int'(vic_v), int'(vv));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk("R1", "phys rsp_valid in reset", int'(rv_p), 0);
        chk("R1", "virt rsp_valid in reset", int'(rv_v), 0);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].is_fill) begin
                do_fill(VEC[i].va, VEC[i].pa, VEC[i].way);
            end else begin
                look(VEC[i].va, VEC[i].pa, $sformatf("row%0d", i),
                     VEC[i].hp, VEC[i].wp, VEC[i].hv, VEC[i].wv);
            end
        end

        // R2: no response without request
        @(negedge clk);
        chk("R2", "phys idle rsp_valid", int'(rv_p), 0);
        chk("R2", "virt idle rsp_valid", int'(rv_v), 0);

        // R9: round-robin victim in set 5
        look(32'h0002_00A0, 32'h0002_00A0, "R9", 1'b0, 2'd0, 1'b0, 2'd0);
        vic("R9 after reset", 2'd0, 2'd0);
        do_fill(32'h0002_00A0, 32'h0002_00A0, 2'd0);
        look(32'h0002_20A0, 32'h0002_20A0, "R9", 1'b0, 2'd0, 1'b0, 2'd0);
        vic("R9 after way0", 2'd1, 2'd1);
        do_fill(32'h0002_20A0, 32'h0002_20A0, 2'd1);
        look(32'h0002_40A0, 32'h0002_40A0, "R9", 1'b0, 2'd0, 1'b0, 2'd0);
        vic("R9 after way1", 2'd2, 2'd2);
        way_en = 4'b0111;
        do_fill(32'h0002_40A0, 32'h0002_40A0, 2'd2);
        look(32'h0002_60A0, 32'h0002_60A0, "R9", 1'b0, 2'd0, 1'b0, 2'd0);
        vic("R9 skip disabled", 2'd0, 2'd0);
        look(32'h0002_40A0, 32'h0002_40A0, "R7", 1'b1, 2'd2, 1'b1, 2'd2);

        // R7: disabled way never hits
        way_en = 4'b1011;
        look(32'h0002_40A0, 32'h0002_40A0, "R7 disabled", 1'b0, 2'd0, 1'b0, 2'd0);
        vic("R9 wrap to 3", 2'd3, 2'd3);
        // R8: fill to disabled way ignored
        do_fill(32'h0002_80A0, 32'h0002_80A0, 2'd2);
        way_en = 4'b1111;
        look(32'h0002_80A0, 32'h0002_80A0, "R8 ignored fill", 1'b0, 2'd0, 1'b0, 2'd0);
        vic("R8 pointer kept", 2'd3, 2'd3);
        look(32'h0002_40A0, 32'h0002_40A0, "R8 line kept", 1'b1, 2'd2, 1'b1, 2'd2);

        // R10 / R5: direct-mapped in set 9
        way_en = 4'b0001;
        look(32'h0000_A120, 32'h0020_0120, "R10", 1'b0, 2'd0, 1'b0, 2'd0);
        vic("R10 empty", 2'd0, 2'd0);
        do_fill(32'h0000_A120, 32'h0020_0120, 2'd0);
        look(32'h0000_C120, 32'h0020_0120, "R5 one way", 1'b1, 2'd0, 1'b0, 2'd0);
        chk("R10", "virt victim", int'(vic_v), 0);
        do_fill(32'h0000_C120, 32'h0020_0120, 2'd0);
        look(32'h0000_A120, 32'h0020_0120, "R10 replaced", 1'b1, 2'd0, 1'b0, 2'd0);
        chk("R10", "virt victim replaced", int'(vic_v), 0);
        look(32'h0000_C120, 32'h0020_0120, "R10 new line", 1'b1, 2'd0, 1'b1, 2'd0);
        way_en = 4'b1111;

        // R1: reset clears all lines
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "phys rsp_valid reset", int'(rv_p), 0);
        rst = 1'b0;
        look(32'h0000_2040, 32'h8000_0040, "R1 cleared", 1'b0, 2'd0, 1'b0, 2'd0);
        vic("R1 pointer cleared", 2'd0, 2'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule